// File: doc/BRIEF.md
# Rotate-Right-by-Constant Decode and Execute Unit

This unit accepts one 32-bit instruction word per cycle, together with a selector that says which of two encodings the word uses: a single-word encoding or a dual-halfword encoding. The unit checks whether the word is the rotate-right-by-constant operation. If it is, the unit pulls out the destination index, the operand index, the 5-bit rotate amount and the flag-update bit. It then rotates the supplied 32-bit operand. A rotate amount of zero does not mean "no rotation". It selects a one-bit rotate through the carry flag.

The result, the write strobe with its register index, and the N/Z/C flag values are registered once, so they appear one cycle after the valid input. Condition evaluation and register file access are handled outside this unit. A word that matches neither pattern raises `no_match`. A dual-halfword word that names register 13 or 15 raises `bad_reg`. In both cases nothing is written and no flag is updated.

Top module: `rotimm_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `wr_en`, `flag_we`, `no_match`, `bad_reg`, `wr_idx` and `result` are all zero.
- R2: With `form_sel`=0, the word matches when insn[27:21]=0001101 and insn[6:4]=110. In that case the flag-update bit is insn[20], the destination is insn[15:12], the rotate amount is insn[11:7] and the operand index is insn[3:0]. Bits [31:28] and [19:16] are ignored, and every register index is accepted.
- R3: With `form_sel`=1, the word matches when insn[31:21]=11101010010, insn[19:16]=1111 and insn[5:4]=11. In that case the flag-update bit is insn[20], the destination is insn[11:8], the operand index is insn[3:0] and the rotate amount is {insn[14:12], insn[7:6]}. Bit 15 is ignored.
- R4: For a nonzero amount k, `result`[i] = `src_val`[(i+k) mod 32] for every bit i.
- R5: For an amount of zero, `result` = {`carry_in`, `src_val`[31:1]} and the carry out is `src_val`[0].
- R6: `flag_we` is 1 only for a matched, permitted word whose flag-update bit is 1. When it is 1: `flag_n`=result[31]; `flag_z`=1 exactly when the result is zero; `flag_c` equals result[31] for a nonzero amount and `src_val`[0] for an amount of zero.
- R7: With `form_sel`=1, a matched word whose destination or operand index is 13 or 15 raises `bad_reg`, with `wr_en`=0 and `flag_we`=0.
- R8: A word that does not match the pattern chosen by `form_sel` raises `no_match`, with `wr_en`=0 and `flag_we`=0.
- R9: Each output is registered with a one-cycle latency. `out_valid` follows `in_valid` by one cycle. `wr_en`, `flag_we`, `no_match` and `bad_reg` are zero in cycles where `out_valid` is 0. For a matched, permitted word, `wr_en`=1 and `wr_idx` is the destination index. At most one of `wr_en`, `no_match` and `bad_reg` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input word is valid this cycle |
| form_sel | input | 1 | Encoding of the word: 0 single-word, 1 dual-halfword (first halfword in [31:16]) |
| insn | input | 32 | Instruction word |
| src_val | input | 32 | Value of the operand register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs hold a result for one word |
| wr_en | output | 1 | Write the result to the register file |
| wr_idx | output | 4 | Destination register index |
| result | output | 32 | Rotated value |
| flag_we | output | 1 | Update N/Z/C |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| no_match | output | 1 | The word is not this operation |
| bad_reg | output | 1 | Dual-halfword word names a disallowed register |

## Verification
Several properties are checked on every cycle:
- the output strobes are mutually exclusive, and each one is gated by `out_valid`;
- a missing or disallowed match suppresses writes and flag updates;
- N and Z agree with the registered result;
- every nonzero rotation can be undone by the matching left rotation.

Other behaviours can only be shown by the bench's scenarios:
- the field positions in both encodings;
- the choice between the carry-rotate path and the normal rotation at amount zero;
- the exact carry value in each path;
- the register indices that the dual-halfword form rejects.

These scenarios use both directed corner words and seeded random words, including words with one opcode bit corrupted.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int WORD_W  = 32;
  localparam int REG_W   = 4;
  localparam int SHAMT_W = $clog2(WORD_W);
  localparam int N_FORMS = 2;

  typedef struct packed {
    logic               hit;
    logic               setf;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   opnd;
    logic [SHAMT_W-1:0] amt;
    logic               forbidden;
  } dec_t;

  function automatic logic [WORD_W-1:0] rot_right(input logic [WORD_W-1:0] v,
                                                   input logic [SHAMT_W-1:0] k);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} >> k;
    return dbl[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] rot_left(input logic [WORD_W-1:0] v,
                                                 input logic [SHAMT_W-1:0] k);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << k;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] carry_rot(input logic [WORD_W-1:0] v,
                                                  input logic c);
    return {c, v[WORD_W-1:1]};
  endfunction

  function automatic logic reg_forbidden(input logic [REG_W-1:0] r);
    return (r == 4'd13) || (r == 4'd15);
  endfunction
endpackage

// File: rtl/rotimm_form_dec.sv
module rotimm_form_dec
  import rotimm_pkg::*;
#(
  parameter bit DUAL = 1'b0
) (
  input  logic [WORD_W-1:0] insn,
  output dec_t              dec
);
  generate
    if (DUAL) begin : g_dual
      logic hi_ok, lo_ok;
      assign hi_ok = (insn[31:21] == 11'b11101010010) && (insn[19:16] == 4'b1111);
      assign lo_ok = (insn[5:4] == 2'b11);
      always_comb begin
        dec.hit       = hi_ok && lo_ok;
        dec.setf      = insn[20];
        dec.dst       = insn[11:8];
        dec.opnd      = insn[3:0];
        dec.amt       = {insn[14:12], insn[7:6]};
        dec.forbidden = reg_forbidden(insn[11:8]) || reg_forbidden(insn[3:0]);
      end
    end else begin : g_single
      always_comb begin
        dec.hit       = (insn[27:21] == 7'b0001101) && (insn[6:4] == 3'b110);
        dec.setf      = insn[20];
        dec.dst       = insn[15:12];
        dec.opnd      = insn[3:0];
        dec.amt       = insn[11:7];
        dec.forbidden = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/rotimm_shift_core.sv
module rotimm_shift_core
  import rotimm_pkg::*;
(
  input  logic [WORD_W-1:0]  src,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               c_in,
  output logic [WORD_W-1:0]  res,
  output logic               c_out,
  output logic               amt_zero
);
  logic [WORD_W-1:0] rot_res;
  logic [WORD_W-1:0] ext_res;

  assign amt_zero = (amt == '0);
  assign rot_res  = rot_right(src, amt);
  assign ext_res  = carry_rot(src, c_in);

  always_comb begin
    if (amt_zero) begin
      res   = ext_res;
      c_out = src[0];
    end else begin
      res   = rot_res;
      c_out = rot_res[WORD_W-1];
    end
  end

  // R4: a nonzero rotation is undone by the left rotation
  always_comb begin
    if (!amt_zero) begin
      a_r4_rot_inverse: assert (rot_left(res, amt) == src);
    end
  end
endmodule

// File: rtl/rotimm_unit.sv
module rotimm_unit
  import rotimm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               form_sel,
  input  logic [WORD_W-1:0]  insn,
  input  logic [WORD_W-1:0]  src_val,
  input  logic               carry_in,
  output logic               out_valid,
  output logic               wr_en,
  output logic [REG_W-1:0]   wr_idx,
  output logic [WORD_W-1:0]  result,
  output logic               flag_we,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               no_match,
  output logic               bad_reg
);
  dec_t dec_v [N_FORMS];

  genvar f;
  generate
    for (f = 0; f < N_FORMS; f++) begin : g_form
      rotimm_form_dec #(.DUAL(f == 1)) u_dec (
        .insn (insn),
        .dec  (dec_v[f])
      );
    end
  endgenerate

  dec_t sel_dec;
  assign sel_dec = form_sel ? dec_v[1] : dec_v[0];

  logic [WORD_W-1:0] core_res;
  logic              core_c;
  logic              core_amt_zero;

  rotimm_shift_core u_core (
    .src      (src_val),
    .amt      (sel_dec.amt),
    .c_in     (carry_in),
    .res      (core_res),
    .c_out    (core_c),
    .amt_zero (core_amt_zero)
  );

  // named events for checking
  logic ev_accept, ev_miss, ev_reject;
  assign ev_accept = in_valid && sel_dec.hit && !sel_dec.forbidden;
  assign ev_miss   = in_valid && !sel_dec.hit;
  assign ev_reject = in_valid && sel_dec.hit && sel_dec.forbidden;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      result    <= '0;
      flag_we   <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      no_match  <= 1'b0;
      bad_reg   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= ev_accept;
      flag_we   <= ev_accept && sel_dec.setf;
      no_match  <= ev_miss;
      bad_reg   <= ev_reject;
      if (in_valid) begin
        wr_idx <= sel_dec.dst;
        result <= core_res;
        flag_n <= core_res[WORD_W-1];
        flag_z <= (core_res == '0);
        flag_c <= core_c;
      end
    end
  end

  // R9: outputs follow the input valid by one cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(wr_en || flag_we || no_match || bad_reg));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, no_match, bad_reg}));
  // R8: no effect on a miss
  a_r8_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> !wr_en && !flag_we);
  // R7: disallowed registers suppress the write
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    bad_reg |-> !wr_en && !flag_we);
  // R6: N/Z agree with the registered result
  a_r6_nz: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_n == result[WORD_W-1]) && (flag_z == (result == '0)) && wr_en);
endmodule

// File: tb/rotimm_unit_tb.sv
module rotimm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        form_sel = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] src_val = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, wr_en, flag_we, flag_n, flag_z, flag_c, no_match, bad_reg;
  logic [3:0]  wr_idx;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rotimm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_sel(form_sel),
    .insn(insn), .src_val(src_val), .carry_in(carry_in),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx), .result(result),
    .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .no_match(no_match), .bad_reg(bad_reg)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_single(input logic [3:0] cond, input logic s,
      input logic [3:0] dst, input logic [4:0] k, input logic [3:0] opnd,
      input logic [3:0] junk);
    return {cond, 7'b0001101, s, junk, dst, k, 3'b110, opnd};
  endfunction

  function automatic logic [31:0] enc_dual(input logic s, input logic [3:0] dst,
      input logic [4:0] k, input logic [3:0] opnd, input logic b15);
    return {11'b11101010010, s, 4'b1111, b15, k[4:2], dst, k[1:0], 2'b11, opnd};
  endfunction

  // bitwise restatement of the rotation
  function automatic logic [31:0] model_res(input logic [31:0] v, input int k,
                                            input logic c);
    logic [31:0] r;
    if (k == 0) begin
      r[31] = c;
      for (int i = 0; i < 31; i++) r[i] = v[i+1];
    end else begin
      for (int i = 0; i < 32; i++) r[i] = v[(i + k) % 32];
    end
    return r;
  endfunction

  // kind: 0 accept, 1 miss, 2 forbidden
  task automatic run(input logic fs, input logic [31:0] w, input logic [31:0] v,
                     input logic c, input int kind, input logic s,
                     input logic [3:0] dst, input int k);
    logic [31:0] er;
    logic ec;
    @(negedge clk);
    in_valid = 1'b1; form_sel = fs; insn = w; src_val = v; carry_in = c;
    @(negedge clk);
    in_valid = 1'b0;
    insn = $urandom; src_val = $urandom;
    er = model_res(v, k, c);
    ec = (k == 0) ? v[0] : er[31];
    chk(out_valid == 1'b1, "R9 out_valid", {31'b0, out_valid}, 32'd1);
    chk(wr_en == (kind == 0), "R9 wr_en", {31'b0, wr_en}, {31'b0, kind == 0});
    chk(no_match == (kind == 1), "R8 no_match", {31'b0, no_match}, {31'b0, kind == 1});
    chk(bad_reg == (kind == 2), "R7 bad_reg", {31'b0, bad_reg}, {31'b0, kind == 2});
    chk(flag_we == (kind == 0 && s), "R6 flag_we", {31'b0, flag_we}, {31'b0, kind == 0 && s});
    if (kind == 0) begin
      chk(wr_idx == dst, fs ? "R3 wr_idx" : "R2 wr_idx", {28'b0, wr_idx}, {28'b0, dst});
      chk(result == er, (k == 0) ? "R5 result" : "R4 result", result, er);
      if (s) begin
        chk(flag_n == er[31], "R6 flag_n", {31'b0, flag_n}, {31'b0, er[31]});
        chk(flag_z == (er == 0), "R6 flag_z", {31'b0, flag_z}, {31'b0, er == 0});
        chk(flag_c == ec, (k == 0) ? "R5 carry" : "R6 carry", {31'b0, flag_c}, {31'b0, ec});
      end
    end
    @(negedge clk);
    chk(!out_valid && !wr_en && !flag_we && !no_match && !bad_reg, "R9 idle",
        {27'b0, out_valid, wr_en, flag_we, no_match, bad_reg}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(!out_valid && !wr_en && !flag_we && !no_match && !bad_reg && result == 0 && wr_idx == 0,
        "R1 reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !wr_en && result == 0, "R1 after reset", {31'b0, out_valid}, 32'd0);

    // directed single-word cases (R2): any cond, junk bits, reg 13/15 allowed
    run(0, enc_single(4'hE, 1, 4'd3, 5'd8, 4'd1, 4'h0), 32'h1234_5678, 0, 0, 1, 4'd3, 8);
    run(0, enc_single(4'h0, 1, 4'd15, 5'd1, 4'd13, 4'hA), 32'h8000_0001, 1, 0, 1, 4'd15, 1);
    run(0, enc_single(4'h5, 1, 4'd2, 5'd31, 4'd0, 4'h0), 32'h8000_0000, 0, 0, 1, 4'd2, 31);
    // amount zero: carry rotate (R5)
    run(0, enc_single(4'hE, 1, 4'd4, 5'd0, 4'd5, 4'h0), 32'h0000_0003, 1, 0, 1, 4'd4, 0);
    run(0, enc_single(4'hE, 1, 4'd4, 5'd0, 4'd5, 4'h0), 32'h0000_0001, 0, 0, 1, 4'd4, 0);
    // zero result flags (R6) and no flag update when S=0
    run(0, enc_single(4'hE, 1, 4'd6, 5'd9, 4'd7, 4'h0), 32'h0, 0, 0, 1, 4'd6, 9);
    run(0, enc_single(4'hE, 0, 4'd6, 5'd9, 4'd7, 4'h0), 32'hF0F0_0000, 1, 0, 0, 4'd6, 9);
    // dual-halfword cases (R3), bit 15 ignored
    run(1, enc_dual(1, 4'd9, 5'd5, 4'd2, 0), 32'hDEAD_BEEF, 0, 0, 1, 4'd9, 5);
    run(1, enc_dual(1, 4'd0, 5'd17, 4'd14, 1), 32'h0001_0000, 0, 0, 1, 4'd0, 17);
    run(1, enc_dual(1, 4'd1, 5'd0, 4'd2, 0), 32'h0000_0000, 1, 0, 1, 4'd1, 0);
    // forbidden registers (R7)
    run(1, enc_dual(1, 4'd13, 5'd3, 4'd2, 0), 32'h1, 0, 2, 1, 4'd13, 3);
    run(1, enc_dual(1, 4'd2, 5'd3, 4'd15, 0), 32'h1, 0, 2, 1, 4'd2, 3);
    // form mismatch (R8)
    run(1, enc_single(4'hE, 1, 4'd3, 5'd8, 4'd1, 4'h0), 32'h5, 0, 1, 1, 4'd3, 8);
    run(0, enc_dual(1, 4'd3, 5'd8, 4'd1, 0), 32'h5, 0, 1, 1, 4'd3, 8);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic fs, s, c, corrupt;
      logic [3:0] dst, opnd, cond;
      logic [4:0] k;
      logic [31:0] w, v;
      int kind, pos;
      fs = $urandom_range(1, 0) == 1;
      s = $urandom_range(1, 0) == 1;
      c = $urandom_range(1, 0) == 1;
      dst = 4'($urandom_range(15, 0));
      opnd = 4'($urandom_range(15, 0));
      cond = 4'($urandom_range(15, 0));
      k = ($urandom_range(7, 0) == 0) ? 5'd0 : 5'($urandom_range(31, 0));
      v = $urandom;
      corrupt = $urandom_range(4, 0) == 0;
      if (fs) begin
        w = enc_dual(s, dst, k, opnd, 1'($urandom_range(1, 0)));
        kind = ((dst == 13) || (dst == 15) || (opnd == 13) || (opnd == 15)) ? 2 : 0;
        if (corrupt) begin
          pos = $urandom_range(16, 0);
          if (pos < 11) w[21 + pos] = ~w[21 + pos];
          else if (pos < 15) w[pos + 5] = ~w[pos + 5];
          else w[pos - 11] = ~w[pos - 11];
          kind = 1;
        end
      end else begin
        w = enc_single(cond, s, dst, k, opnd, 4'($urandom_range(15, 0)));
        kind = 0;
        if (corrupt) begin
          pos = $urandom_range(9, 0);
          if (pos < 7) w[21 + pos] = ~w[21 + pos];
          else w[pos - 3] = ~w[pos - 3];
          kind = 1;
        end
      end
      run(fs, w, v, c, kind, s, dst, int'(k));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule